// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog for a processor subsystem. An internal prescaler turns the system clock into count ticks, and an 8-bit up counter advances on each tick. Software must service the watchdog before the counter wraps. Otherwise the block signals a fault, either as a one-cycle reset request or as a held interrupt request.

Servicing is protected by keys. Only the exact key byte written to the code register restarts the counter. A second key byte turns the watchdog off, but only after software has first cleared the enable bit in the control register. An optional half-window mode also treats a service write that comes too early or too late as a fault. This catches code that services the counter in a tight loop.

Software can read the counter to confirm that it is still moving. It can read a status register that shows whether the watchdog is running and whether an interrupt is pending.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset, the block is in this state:
  - control (address 0) reads 0x03: enable bit [0]=1, reset-select bit [1]=1, period field [3:2]=00, window field [5:4]=00.
  - the watchdog is running.
  - status (address 3) reads 0x01.
  - the counter (address 2) reads 0.
  - `rst_req_o` and `irq_o` are low.
- R2: Writing 0x4E to the code register (address 1) while the watchdog is running returns the counter to 0 at that clock edge. The prescaler also restarts. Counting then continues, one step every 2^(BASE_LOG2+2*period) clocks. The counter value can be read at address 2.
- R3: In reset mode (control[1]=1), the counter wraps from 255 to 0 after 256 steps. `rst_req_o` is then high for exactly the one cycle that follows the wrapping edge.
- R4: In interrupt mode (control[1]=0), a wrap sets status bit [1] and raises `irq_o`. The request stays high until 1 is written to status bit [1]. Writing 0 there has no effect. No reset pulse is produced.
- R5: A 0x4E write in the same cycle as a wrap clears the counter, and no fault is raised.
- R6: Writing 0xB1 to the code register stops the watchdog only if control[0] is 0. While control[0] is 1, the write has no effect. Clearing control[0] alone does not stop the watchdog.
- R7: While the watchdog is stopped:
  - status bit [0] is 0.
  - the counter holds at 0.
  - no fault is raised.
  Writing control with bit [0]=1 restarts it from zero.
- R8: Any code-register value other than 0x4E and 0xB1 is ignored.
- R9: With window field 10, a 0x4E write is legal only while the counter reads 128..254. Window codes 00, 01 and 11 allow service at any time.
- R10: An illegal service write raises the selected fault at the following edge, the same way a wrap does. The counter still restarts.
- R11: Period codes 00, 01, 10 and 11 give a step of 2^BASE_LOG2, 2^(BASE_LOG2+2), 2^(BASE_LOG2+4) and 2^(BASE_LOG2+6) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 code, 2 counter, 3 status |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Held interrupt request |

## Verification
The bench times service writes so that the counter value during the write cycle sits exactly on the window edges:
- At 127 and 255, a design with an off-by-one comparison would miss the fault.
- At 128 and 254, the same error would raise a false fault.

One service write lands on the very edge where the counter wraps. A design that lets the wrap win would emit a reset pulse there.

The bench also checks the key gating:
- It sends the stop key while the enable bit is set, then checks that the counter kept moving. A design that ignores the gate would stop.
- It writes near-miss codes and checks that the counter was not restarted by mistake.

A scoreboard predicts the edge of every reset pulse and flags any pulse that is missing, early, late or extra.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned DW = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CODE = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam logic [DW-1:0] KEY_CLEAR   = 8'h4E;
  localparam logic [DW-1:0] KEY_DISABLE = 8'hB1;

  localparam logic [1:0] WIN_HALF = 2'b10;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_IRQ = 1;

  typedef struct packed {
    logic [1:0] win;
    logic [1:0] tsel;
    logic       rst_sel;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{win: 2'b00, tsel: 2'b00, rst_sel: 1'b1, en: 1'b1};
endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned STEP      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] tsel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned PW   = BASE_LOG2 + STEP * (NSEL - 1);

  logic [PW-1:0]   pre_q;
  logic [NSEL-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pre_q <= '0;
    else if (!run_i || restart_i)  pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

  // one terminal-count tap per period code
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign tap[g] = &pre_q[BASE_LOG2 + STEP * g - 1 : 0];
  end

  assign tick_o = run_i & tap[tsel_i];
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter import wdk_pkg::*; #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [1:0]       win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             clr_ok_o
);
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || restart_i)  cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o   = run_i & tick_i & (cnt_q == TOP);
  // half window: past half period, at least one step before wrap
  assign clr_ok_o = (win_i != WIN_HALF) || ((cnt_q >= HALF) && (cnt_q != TOP));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs import wdk_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          fault_i,
  output ctrl_t         ctrl_o,
  output logic          active_o,
  output logic          irq_st_o,
  output logic          rst_req_o,
  output logic          clr_key_o,
  output logic          stat_clr_o
);
  ctrl_t ctrl_q;
  logic  active_q, irq_q, rst_q;
  logic  ctrl_wr, code_wr, stat_wr, dis_key;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign code_wr = wr_en_i && (wr_addr_i == A_CODE);
  assign stat_wr = wr_en_i && (wr_addr_i == A_STAT);

  assign clr_key_o  = code_wr && (wr_data_i == KEY_CLEAR) && active_q;
  assign dis_key    = code_wr && (wr_data_i == KEY_DISABLE) && !ctrl_q.en;
  assign stat_clr_o = stat_wr && wr_data_i[ST_IRQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        active_q <= 1'b1;
    else if (ctrl_wr && wr_data_i[0])   active_q <= 1'b1;
    else if (dis_key)                   active_q <= 1'b0;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         irq_q <= 1'b0;
    else if (fault_i && !ctrl_q.rst_sel) irq_q <= 1'b1;
    else if (stat_clr_o)                 irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= fault_i && ctrl_q.rst_sel;
  end

  assign ctrl_o    = ctrl_q;
  assign active_o  = active_q;
  assign irq_st_o  = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt import wdk_pkg::*; #(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned CNT_W     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rst_req_o,
  output logic          irq_o
);
  ctrl_t            ctrl;
  logic             active, irq_st, clr_key, stat_clr;
  logic             tick, wrap, clr_ok, fault;
  logic [CNT_W-1:0] cnt;

  wdk_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .fault_i    (fault),
    .ctrl_o     (ctrl),
    .active_o   (active),
    .irq_st_o   (irq_st),
    .rst_req_o  (rst_req_o),
    .clr_key_o  (clr_key),
    .stat_clr_o (stat_clr)
  );

  wdk_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(2), .STEP(2)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .restart_i (clr_key),
    .tsel_i    (ctrl.tsel),
    .tick_o    (tick)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .restart_i (clr_key),
    .tick_i    (tick),
    .win_i     (ctrl.win),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .clr_ok_o  (clr_ok)
  );

  // a service write suppresses a coincident wrap; a mistimed one is a fault itself
  assign fault = (wrap && !clr_key) || (clr_key && !clr_ok);

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:  rd_data_o = {{(DW-CTRL_W){1'b0}}, ctrl};
      A_CNT:   rd_data_o = DW'(cnt);
      A_STAT: begin
        rd_data_o[ST_ACT] = active;
        rd_data_o[ST_IRQ] = irq_st;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_st;
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker import wdk_pkg::*; #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic             active,
  input logic             ctrl_en,
  input logic             rst_sel,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             clr_key,
  input logic             clr_ok,
  input logic             stat_clr,
  input logic             rst_req_o,
  input logic             irq_o
);
  logic dis_write;
  assign dis_write = wr_en_i && (wr_addr_i == A_CODE) && (wr_data_i == KEY_DISABLE);

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_key |=> (cnt == '0));

  a_r3_wrap_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !clr_key && rst_sel) |=> rst_req_o);

  a_r4_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_clr) |=> irq_o);

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && clr_key && clr_ok) |=> (!rst_req_o && cnt == '0));

  a_r6_disable_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_write && ctrl_en && active) |=> active);

  a_r7_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (cnt == '0));

  a_r10_bad_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_key && !clr_ok && rst_sel) |=> rst_req_o);
endmodule

bind keyed_window_wdt wdk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .active    (active),
  .ctrl_en   (ctrl.en),
  .rst_sel   (ctrl.rst_sel),
  .cnt       (cnt),
  .wrap      (wrap),
  .clr_key   (clr_key),
  .clr_ok    (clr_ok),
  .stat_clr  (stat_clr),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o)
);

// File: tb/keyed_window_wdt_tb.sv
`timescale 1ns/1ps
module keyed_window_wdt_tb;
  localparam int unsigned B = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       rst_req_o, irq_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct { int at; string tag; } exp_t;
  exp_t q[$];

  keyed_window_wdt #(.BASE_LOG2(B), .CNT_W(8)) u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // scoreboard monitor for reset pulses
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rst_req_o) begin
        checks++;
        if (q.size() > 0 && q[0].at == cyc) q.pop_front();
        else begin
          errors++;
          $display("FAIL R3 unexpected rst_req_o pulse: actual cycle %0d expected %0d",
                   cyc, (q.size() > 0) ? q[0].at : -1);
        end
      end else if (q.size() > 0 && q[0].at <= cyc) begin
        checks++; errors++;
        $display("FAIL %s missing rst_req_o pulse: actual 0 expected 1 at cycle %0d",
                 q[0].tag, q[0].at);
        q.pop_front();
      end
    end
  end

  task automatic push(input int at, input string tag);
    exp_t e; e.at = at; e.tag = tag; q.push_back(e);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr_i = a; #1; d = int'(rd_data_o);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; e = cyc + 1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_at(input int e, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    while (cyc < e - 1) @(negedge clk_i);
    chk("schedule", cyc, e - 1);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_to(input int n);
    @(negedge clk_i);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    int d, e, c, c2, c3, c4, eo;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 8'h03);
    rd(2'd3, d); chk("R1 status", d, 8'h01);
    rd(2'd2, d); chk("R1 counter", d, 0);
    chk("R1 rst_req_o", rst_req_o, 0);
    chk("R1 irq_o", irq_o, 0);

    // R2 service restarts and counting continues
    wr(2'd1, 8'h4E, c);
    wait_to(c + 40); rd(2'd2, d); chk("R2 count after 40", d, 10);
    wr_at(c + 600, 2'd1, 8'h4E); c2 = c + 600;
    wr_at(c2 + 1000, 2'd1, 8'h4E); c3 = c2 + 1000;
    wait_to(c3 + 800); rd(2'd2, d); chk("R2 count after 800", d, 200);

    // R3 wrap in reset mode
    eo = c3 + 1024;
    push(eo, "R3");
    wait_to(eo); rd(2'd2, d); chk("R3 wrapped to zero", d, 0);

    // R5 service on the wrapping edge
    wr_at(eo + 1024, 2'd1, 8'h4E); c = eo + 1024;
    wait_to(c + 6); rd(2'd2, d); chk("R5 cleared on coincidence", d, 1);

    // R4 interrupt mode
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'h4E, c);
    wait_to(c + 1023); chk("R4 irq before wrap", irq_o, 0);
    wait_to(c + 1024); chk("R4 irq on wrap", irq_o, 1);
    rd(2'd3, d); chk("R4 status", d, 8'h03);
    wait_to(c + 1074); chk("R4 irq held", irq_o, 1);
    wr(2'd3, 8'h01, e);
    chk("R4 write 0 keeps irq", irq_o, 1);
    wr(2'd3, 8'h02, e);
    chk("R4 w1c clears irq", irq_o, 0);
    rd(2'd3, d); chk("R4 status after clear", d, 8'h01);

    // R8 other codes ignored
    wr(2'd1, 8'h4E, c);
    wr_at(c + 100, 2'd1, 8'h55);
    wr_at(c + 104, 2'd1, 8'h4F);
    wait_to(c + 200); rd(2'd2, d); chk("R8 non-key ignored", d, 50);

    // R6 stop key blocked while enable set
    wr_at(c + 300, 2'd1, 8'hB1);
    wait_to(c + 400);
    rd(2'd3, d); chk("R6 still running", d, 8'h01);
    rd(2'd2, d); chk("R6 counter moving", d, 100);
    wr(2'd0, 8'h00, e);
    rd(2'd3, d); chk("R6 enable bit alone does not stop", d, 8'h01);
    wr(2'd1, 8'hB1, e);
    rd(2'd3, d); chk("R6 stopped by key", d, 8'h00);

    // R7 stopped state
    wait_to(e + 3000);
    rd(2'd2, d); chk("R7 counter held", d, 0);
    chk("R7 no irq", irq_o, 0);
    wr(2'd0, 8'h03, e);
    rd(2'd3, d); chk("R7 re-enabled", d, 8'h01);
    push(e + 1024, "R7");
    wait_to(e + 1030);

    // R9 / R10 half window, reset mode
    wr(2'd1, 8'h4E, c);
    wr(2'd0, 8'h23, e);
    wr_at(c + 513, 2'd1, 8'h4E); c = c + 513;        // counter 128: legal
    wr_at(c + 511, 2'd1, 8'h4E); push(c + 511, "R10"); c = c + 511; // 127: illegal
    wr_at(c + 1019, 2'd1, 8'h4E); c = c + 1019;      // 254: legal
    wr_at(c + 1022, 2'd1, 8'h4E); push(c + 1022, "R10"); c4 = c + 1022; // 255: illegal
    wait_to(c4 + 8); rd(2'd2, d); chk("R10 counter restarted", d, 2);

    // R10 interrupt mode illegal service
    wr(2'd0, 8'h21, e);
    wr(2'd1, 8'h4E, e);
    chk("R10 irq on early service", irq_o, 1);
    wr(2'd3, 8'h02, e);
    // R9 window codes 01 and 11 act as open
    wr(2'd0, 8'h11, e);
    wr(2'd1, 8'h4E, e);
    wr(2'd0, 8'h31, e);
    wr(2'd1, 8'h4E, e);
    wait_to(e + 2);
    chk("R9 open window codes no fault", irq_o, 0);

    // R11 period select 01
    wr(2'd0, 8'h05, e);
    wr(2'd1, 8'h4E, c);
    wait_to(c + 160); rd(2'd2, d); chk("R11 step every 16", d, 10);
    wait_to(c + 4095); chk("R11 no irq before wrap", irq_o, 0);
    wait_to(c + 4096); chk("R11 irq at wrap", irq_o, 1);

    wait_to(cyc + 4);
    chk("scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule